// File: doc/BRIEF.md
# Register Transfer and Exchange Sequencer

This block holds a small register file and runs two register-move operations on it: a transfer, which copies one register into another, and an exchange, which swaps two registers. A one-cycle start strobe launches an operation. The operation select and a postbyte are sampled on the same edge. The postbyte names the two registers. The block raises busy for the whole fixed-length micro-sequence and then pulses done for one cycle. The contents of every register are visible at all times on wide read ports.

The sequence keeps to a fixed cycle plan, whatever the widths of the two registers:

- The first two busy cycles stand in for opcode and postbyte fetch, and nothing is written in them.
- Every two-cycle step then moves one 16-bit value a byte at a time over an 8-bit path, low byte first, then high byte.
- Data always passes through an internal temporary register.
- An 8-bit register is always moved as a 16-bit quantity, so a move between two 8-bit registers costs exactly as many cycles as a move between two 16-bit ones.

Top module: `regmove_seq`

## Requirements
- R1: A transfer with postbyte {first, second} leaves the second register equal to the old value of the first, leaves every other register unchanged, and keeps busy high for exactly 6 cycles after the accepting edge.
- R2: An exchange swaps the values of the first and second registers, leaves every other register unchanged, and keeps busy high for exactly 8 cycles after the accepting edge.
- R3: The postbyte bits [7:4] select the first (source) register and bits [3:0] select the second (destination) register. Codes 0 to 5 are 16-bit registers. Codes 8 to 11 are 8-bit registers. Operation select 0 is a transfer and 1 is an exchange. An 8-bit register read as a 16-bit value has its upper byte at 8'hFF. Writing a 16-bit value into an 8-bit register keeps only the low byte.
- R4: No register changes while the block is idle or during busy cycles 1 to 4 of any operation.
- R5: A start strobe that arrives while busy is high has no effect on the running operation, its result, or its timing.
- R6: Done is high for exactly one cycle, the cycle right after the last busy cycle. Busy is low in that cycle, and a start in that cycle is accepted.
- R7: An exchange of a register with itself leaves its value unchanged.
- R8: Codes 6, 7 and 12 to 15 name no register. Such a code reads as 16'hFFFF, and a write to it is dropped.
- R9: After reset, busy and done are low. Each 16-bit register k holds its nibble k+1 repeated four times (register 0 holds 16'h1111). Each 8-bit register j (code 8+j) holds 8'hC0 + 8'h11*j.
- R10: The cycle count of an operation depends only on the operation select, never on the widths or codes of the registers.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Start strobe, taken only while idle |
| op_i | input | 1 | 0 = transfer, 1 = exchange |
| postbyte_i | input | 8 | [7:4] first register code, [3:0] second register code |
| busy_o | output | 1 | High while an operation runs |
| done_o | output | 1 | One-cycle pulse after the final write |
| wide_o | output | N_WIDE*16 | 16-bit registers, register k at bits [16k+15:16k] |
| byte_o | output | N_BYTE*8 | 8-bit registers, register j at bits [8j+7:8j] |

## Verification
The bench builds the block with its default parameters: six 16-bit and four 8-bit registers, with the 8-bit group based at code 8. With these values a 4-bit code covers every valid register as well as the unused codes 6, 7 and 12 to 15. Random postbytes therefore also reach the invalid-code behaviour and every mix of widths, including self-exchange. Injected start strobes at random busy cycles, and back-to-back launches in the done cycle, exercise the ignore rule and the handover at the end of an operation.

// File: rtl/regmove_pkg.sv
package regmove_pkg;

    localparam int CODE_W      = 4;
    localparam int DATA_W      = 16;
    localparam int BYTE_W      = 8;
    localparam int STEP_W      = 4;
    localparam int XFER_LEN    = 6;
    localparam int XCHG_LEN    = 8;
    localparam int FETCH_STEPS = 2;

    typedef logic [CODE_W-1:0] code_t;
    typedef logic [STEP_W-1:0] step_t;

    typedef enum logic {
        OP_XFER = 1'b0,
        OP_XCHG = 1'b1
    } op_e;

    // One micro-operation, valid for a single cycle of the sequence
    typedef struct packed {
        logic  tmp_we;    // load a byte of the temporary register
        logic  rf_we;     // write a byte of the register file
        logic  hi;        // byte lane: 0 low, 1 high
        logic  from_tmp;  // write data comes from the temporary register
        code_t rd_code;   // register file read selection
        code_t wr_code;   // register file write selection
    } uop_t;

    function automatic logic [DATA_W-1:0] wide_reset(input int k);
        return {4{4'(k + 1)}};
    endfunction

    function automatic logic [BYTE_W-1:0] byte_reset(input int j);
        return 8'(8'hC0 + 8'h11 * j);
    endfunction

endpackage

// File: rtl/regmove_ctrl.sv
module regmove_ctrl
    import regmove_pkg::*;
(
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  start_i,
    input  logic                  op_i,
    input  logic [2*CODE_W-1:0]   postbyte_i,
    output logic                  busy_o,
    output logic                  done_o,
    output uop_t                  uop_o
);

    typedef struct packed {
        logic  busy;
        logic  done;
        op_e   op;
        step_t step;
        code_t first;
        code_t second;
    } ctrl_t;

    localparam step_t XFER_LAST = step_t'(XFER_LEN);
    localparam step_t XCHG_LAST = step_t'(XCHG_LEN);
    localparam step_t STEP_TMP0 = step_t'(FETCH_STEPS + 1);
    localparam step_t STEP_TMP1 = step_t'(FETCH_STEPS + 2);
    localparam step_t STEP_MID0 = step_t'(FETCH_STEPS + 3);
    localparam step_t STEP_MID1 = step_t'(FETCH_STEPS + 4);
    localparam step_t STEP_END0 = step_t'(FETCH_STEPS + 5);
    localparam step_t STEP_END1 = step_t'(FETCH_STEPS + 6);

    ctrl_t st_d, st_q;
    logic  last_step;

    // Sequence state
    always_comb begin
        st_d      = st_q;
        st_d.done = 1'b0;
        last_step = (st_q.op == OP_XCHG) ? (st_q.step == XCHG_LAST)
                                         : (st_q.step == XFER_LAST);
        if (!st_q.busy) begin
            if (start_i) begin
                st_d.busy   = 1'b1;
                st_d.step   = step_t'(1);
                st_d.op     = op_e'(op_i);
                st_d.first  = postbyte_i[2*CODE_W-1:CODE_W];
                st_d.second = postbyte_i[CODE_W-1:0];
            end
        end else if (last_step) begin
            st_d.busy = 1'b0;
            st_d.done = 1'b1;
            st_d.step = '0;
        end else begin
            st_d.step = st_q.step + step_t'(1);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '{busy: 1'b0, done: 1'b0, op: OP_XFER, step: '0,
                      first: '0, second: '0};
        end else begin
            st_q <= st_d;
        end
    end

    // Micro-operation decode for the current step
    always_comb begin
        uop_o         = '0;
        uop_o.rd_code = st_q.first;
        uop_o.wr_code = st_q.second;
        if (st_q.busy) begin
            unique case (st_q.step)
                STEP_TMP0, STEP_TMP1: begin
                    uop_o.tmp_we  = 1'b1;
                    uop_o.rd_code = st_q.first;
                    uop_o.hi      = (st_q.step == STEP_TMP1);
                end
                STEP_MID0, STEP_MID1: begin
                    uop_o.rf_we = 1'b1;
                    uop_o.hi    = (st_q.step == STEP_MID1);
                    if (st_q.op == OP_XCHG) begin
                        uop_o.from_tmp = 1'b0;
                        uop_o.rd_code  = st_q.second;
                        uop_o.wr_code  = st_q.first;
                    end else begin
                        uop_o.from_tmp = 1'b1;
                        uop_o.wr_code  = st_q.second;
                    end
                end
                STEP_END0, STEP_END1: begin
                    uop_o.rf_we    = (st_q.op == OP_XCHG);
                    uop_o.hi       = (st_q.step == STEP_END1);
                    uop_o.from_tmp = 1'b1;
                    uop_o.wr_code  = st_q.second;
                end
                default: begin
                    uop_o.tmp_we = 1'b0;
                    uop_o.rf_we  = 1'b0;
                end
            endcase
        end
    end

    assign busy_o = st_q.busy;
    assign done_o = st_q.done;

endmodule

// File: rtl/regmove_tmp.sv
module regmove_tmp
    import regmove_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              we,
    input  logic              hi,
    input  logic [BYTE_W-1:0] din,
    output logic [DATA_W-1:0] dout
);

    logic [DATA_W-1:0] tmp_d, tmp_q;

    always_comb begin
        tmp_d = tmp_q;
        if (we) begin
            if (hi) tmp_d[DATA_W-1:BYTE_W] = din;
            else    tmp_d[BYTE_W-1:0]      = din;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) tmp_q <= '0;
        else        tmp_q <= tmp_d;
    end

    assign dout = tmp_q;

endmodule

// File: rtl/regmove_regfile.sv
module regmove_regfile
    import regmove_pkg::*;
#(
    parameter int N_WIDE    = 6,
    parameter int N_BYTE    = 4,
    parameter int BYTE_BASE = 8
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     we,
    input  logic                     hi,
    input  code_t                    wr_code,
    input  logic [BYTE_W-1:0]        wr_data,
    input  code_t                    rd_code,
    output logic [DATA_W-1:0]        rd_data,
    output logic [N_WIDE*DATA_W-1:0] wide_o,
    output logic [N_BYTE*BYTE_W-1:0] byte_o
);

    localparam logic [BYTE_W-1:0] PAD = '1;

    typedef struct packed {
        logic [N_WIDE-1:0][DATA_W-1:0] wide;
        logic [N_BYTE-1:0][BYTE_W-1:0] bytes;
    } rf_t;

    rf_t rf_d, rf_q;

    logic [N_WIDE-1:0] wr_hit_w, rd_hit_w;
    logic [N_BYTE-1:0] wr_hit_b, rd_hit_b;

    // Address decode for each register
    for (genvar k = 0; k < N_WIDE; k++) begin : g_wide_dec
        assign wr_hit_w[k] = (wr_code == code_t'(k));
        assign rd_hit_w[k] = (rd_code == code_t'(k));
        assign wide_o[k*DATA_W +: DATA_W] = rf_q.wide[k];
    end

    for (genvar j = 0; j < N_BYTE; j++) begin : g_byte_dec
        assign wr_hit_b[j] = (wr_code == code_t'(BYTE_BASE + j));
        assign rd_hit_b[j] = (rd_code == code_t'(BYTE_BASE + j));
        assign byte_o[j*BYTE_W +: BYTE_W] = rf_q.bytes[j];
    end

    function automatic rf_t reset_image();
        rf_t img;
        for (int k = 0; k < N_WIDE; k++) img.wide[k]  = wide_reset(k);
        for (int j = 0; j < N_BYTE; j++) img.bytes[j] = byte_reset(j);
        return img;
    endfunction

    // Byte-lane writes; an 8-bit register takes only the low lane
    always_comb begin
        rf_d = rf_q;
        for (int k = 0; k < N_WIDE; k++) begin
            if (we && wr_hit_w[k]) begin
                if (hi) rf_d.wide[k][DATA_W-1:BYTE_W] = wr_data;
                else    rf_d.wide[k][BYTE_W-1:0]      = wr_data;
            end
        end
        for (int j = 0; j < N_BYTE; j++) begin
            if (we && !hi && wr_hit_b[j]) rf_d.bytes[j] = wr_data;
        end
    end

    // 16-bit read view; unmapped codes read all ones
    always_comb begin
        rd_data = '1;
        for (int k = 0; k < N_WIDE; k++) begin
            if (rd_hit_w[k]) rd_data = rf_q.wide[k];
        end
        for (int j = 0; j < N_BYTE; j++) begin
            if (rd_hit_b[j]) rd_data = {PAD, rf_q.bytes[j]};
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) rf_q <= reset_image();
        else        rf_q <= rf_d;
    end

endmodule

// File: rtl/regmove_seq.sv
module regmove_seq
    import regmove_pkg::*;
#(
    parameter int N_WIDE    = 6,
    parameter int N_BYTE    = 4,
    parameter int BYTE_BASE = 8
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     start_i,
    input  logic                     op_i,
    input  logic [7:0]               postbyte_i,
    output logic                     busy_o,
    output logic                     done_o,
    output logic [N_WIDE*16-1:0]     wide_o,
    output logic [N_BYTE*8-1:0]      byte_o
);

    uop_t              uop;
    logic [DATA_W-1:0] rd_data;
    logic [DATA_W-1:0] tmp_val;
    logic [BYTE_W-1:0] bus_byte;
    logic [DATA_W-1:0] bus_src;

    regmove_ctrl u_ctrl (
        .clk        (clk),
        .rst_n      (rst_n),
        .start_i    (start_i),
        .op_i       (op_i),
        .postbyte_i (postbyte_i),
        .busy_o     (busy_o),
        .done_o     (done_o),
        .uop_o      (uop)
    );

    // Internal 8-bit path: choose the source word, then the lane
    always_comb begin
        bus_src  = uop.from_tmp ? tmp_val : rd_data;
        bus_byte = uop.hi ? bus_src[DATA_W-1:BYTE_W] : bus_src[BYTE_W-1:0];
    end

    regmove_tmp u_tmp (
        .clk   (clk),
        .rst_n (rst_n),
        .we    (uop.tmp_we),
        .hi    (uop.hi),
        .din   (uop.hi ? rd_data[DATA_W-1:BYTE_W] : rd_data[BYTE_W-1:0]),
        .dout  (tmp_val)
    );

    regmove_regfile #(
        .N_WIDE    (N_WIDE),
        .N_BYTE    (N_BYTE),
        .BYTE_BASE (BYTE_BASE)
    ) u_rf (
        .clk     (clk),
        .rst_n   (rst_n),
        .we      (uop.rf_we),
        .hi      (uop.hi),
        .wr_code (uop.wr_code),
        .wr_data (bus_byte),
        .rd_code (uop.rd_code),
        .rd_data (rd_data),
        .wide_o  (wide_o),
        .byte_o  (byte_o)
    );

endmodule

// File: rtl/regmove_chk.sv
module regmove_chk #(
    parameter int N_WIDE = 6,
    parameter int N_BYTE = 4
) (
    input logic                 clk,
    input logic                 rst_n,
    input logic                 start_i,
    input logic                 op_i,
    input logic                 busy_o,
    input logic                 done_o,
    input logic [N_WIDE*16-1:0] wide_o,
    input logic [N_BYTE*8-1:0]  byte_o
);

    // Cycle number within the running operation (1 in the first busy cycle)
    logic [3:0] cyc_q;
    logic [3:0] len_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cyc_q <= '0;
            len_q <= '0;
        end else if (start_i && !busy_o) begin
            cyc_q <= 4'd1;
            len_q <= op_i ? 4'd8 : 4'd6;
        end else if (busy_o) begin
            cyc_q <= cyc_q + 4'd1;
        end
    end

    // R10 / R1 / R2 / R5: done arrives exactly one cycle after the fixed length
    a_r10_fixed_len: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |-> (cyc_q == len_q + 4'd1));

    // R6: done is a single-cycle pulse
    a_r6_done_single: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |=> !done_o);

    // R6: busy is low while done is high
    a_r6_done_idle: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |-> !busy_o);

    // R4: no register write in the fetch and temp-load cycles
    a_r4_early_stable: assert property (@(posedge clk) disable iff (!rst_n)
        (busy_o && cyc_q <= 4'd4) |=> ($stable(wide_o) && $stable(byte_o)));

    // R4: nothing changes while idle
    a_r4_idle_stable: assert property (@(posedge clk) disable iff (!rst_n)
        !busy_o |=> ($stable(wide_o) && $stable(byte_o)));

endmodule

bind regmove_seq regmove_chk #(
    .N_WIDE (N_WIDE),
    .N_BYTE (N_BYTE)
) u_chk (
    .clk     (clk),
    .rst_n   (rst_n),
    .start_i (start_i),
    .op_i    (op_i),
    .busy_o  (busy_o),
    .done_o  (done_o),
    .wide_o  (wide_o),
    .byte_o  (byte_o)
);

// File: tb/regmove_seq_bench.sv
`timescale 1ns/1ps
module regmove_seq_bench;

    localparam int NW = 6;
    localparam int NB = 4;

    logic            clk = 1'b0;
    logic            rst_n = 1'b0;
    logic            start_i = 1'b0;
    logic            op_i = 1'b0;
    logic [7:0]      postbyte_i = '0;
    logic            busy_o, done_o;
    logic [NW*16-1:0] wide_o;
    logic [NB*8-1:0]  byte_o;

    int n_checks = 0;
    int n_err    = 0;
    bit finished = 1'b0;

    logic [15:0] mw [NW];
    logic [7:0]  mb [NB];

    always #5 clk = ~clk;

    regmove_seq u_regmove_seq (
        .clk        (clk),
        .rst_n      (rst_n),
        .start_i    (start_i),
        .op_i       (op_i),
        .postbyte_i (postbyte_i),
        .busy_o     (busy_o),
        .done_o     (done_o),
        .wide_o     (wide_o),
        .byte_o     (byte_o)
    );

    task automatic check(input bit ok, input string req,
                         input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (!ok) begin
            n_err++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    // R3 / R8 model of the 16-bit read view
    function automatic logic [15:0] rd16(input logic [3:0] c);
        if (c < 4'd6)                  return mw[c];
        else if (c >= 4'd8 && c < 4'd12) return {8'hFF, mb[c - 4'd8]};
        else                           return 16'hFFFF;
    endfunction

    task automatic wr16(input logic [3:0] c, input logic [15:0] v);
        if (c < 4'd6)                    mw[c] = v;
        else if (c >= 4'd8 && c < 4'd12) mb[c - 4'd8] = v[7:0];
    endtask

    task automatic check_regs(input string req);
        for (int k = 0; k < NW; k++)
            check(wide_o[k*16 +: 16] == mw[k], req, 32'(wide_o[k*16 +: 16]), 32'(mw[k]));
        for (int j = 0; j < NB; j++)
            check(byte_o[j*8 +: 8] == mb[j], req, 32'(byte_o[j*8 +: 8]), 32'(mb[j]));
    endtask

    // Called at a falling edge; returns at the falling edge of the done cycle
    task automatic run_op(input bit xchg, input logic [7:0] pb, input int inj, input string req);
        logic [NW*16-1:0] wsnap;
        logic [NB*8-1:0]  bsnap;
        logic [15:0] a, b;
        int n, len;
        wsnap = wide_o;
        bsnap = byte_o;
        len = xchg ? 8 : 6;
        start_i = 1'b1; op_i = xchg; postbyte_i = pb;
        @(negedge clk);
        start_i = 1'b0;
        n = 1;
        check(done_o == 1'b0, "R6", 32'(done_o), 0);
        while (!done_o && n < 20) begin
            if (n == inj) begin
                start_i = 1'b1; op_i = ~xchg; postbyte_i = ~pb;   // R5 injection
            end else begin
                start_i = 1'b0;
            end
            check(busy_o == 1'b1, req, 32'(busy_o), 1);
            if (n == 5) begin
                check(wide_o == wsnap, "R4", 32'(wide_o[31:0]), 32'(wsnap[31:0]));
                check(byte_o == bsnap, "R4", 32'(byte_o), 32'(bsnap));
            end
            @(negedge clk);
            n++;
        end
        start_i = 1'b0;
        check(n == len + 1, "R10", 32'(n), 32'(len + 1));
        check(busy_o == 1'b0, "R6", 32'(busy_o), 0);
        a = rd16(pb[7:4]);
        b = rd16(pb[3:0]);
        if (xchg) begin
            wr16(pb[7:4], b);
            wr16(pb[3:0], a);
        end else begin
            wr16(pb[3:0], a);
        end
        check_regs(req);
    endtask

    initial begin
        for (int k = 0; k < NW; k++) mw[k] = {4{4'(k + 1)}};
        for (int j = 0; j < NB; j++) mb[j] = 8'(8'hC0 + 8'h11 * j);
        void'($urandom(32'd20240723));
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R9 reset state
        check(busy_o == 1'b0, "R9", 32'(busy_o), 0);
        check(done_o == 1'b0, "R9", 32'(done_o), 0);
        check_regs("R9");
        // R4 idle: nothing moves over several idle cycles
        repeat (3) @(negedge clk);
        check_regs("R4");

        run_op(1'b0, 8'h12, 0, "R1");   // 16 -> 16
        run_op(1'b0, 8'h80, 0, "R3");   // 8 -> 16, upper byte FF
        run_op(1'b0, 8'h39, 0, "R3");   // 16 -> 8, low byte kept
        run_op(1'b0, 8'h8B, 0, "R1");   // 8 -> 8
        run_op(1'b1, 8'h05, 0, "R2");   // 16 <-> 16
        run_op(1'b1, 8'h4A, 0, "R3");   // 16 <-> 8
        run_op(1'b1, 8'h33, 0, "R7");   // self exchange, 16-bit
        run_op(1'b1, 8'h99, 0, "R7");   // self exchange, 8-bit
        run_op(1'b0, 8'h61, 0, "R8");   // unmapped source reads FFFF
        run_op(1'b0, 8'h2F, 0, "R8");   // unmapped destination dropped
        run_op(1'b1, 8'h07, 0, "R8");   // exchange with unmapped code
        run_op(1'b0, 8'h24, 3, "R5");   // start mid-operation ignored
        run_op(1'b1, 8'h9A, 8, "R5");   // start in last busy cycle ignored
        run_op(1'b0, 8'h51, 6, "R5");

        for (int i = 0; i < 300; i++) begin
            bit xchg;
            int inj;
            xchg = 1'($urandom_range(1));
            inj  = ($urandom_range(3) == 0) ? int'($urandom_range(xchg ? 8 : 6, 1)) : 0;
            run_op(xchg, 8'($urandom_range(255)), inj, xchg ? "R2" : "R1");
        end
        // R6: done drops after its single cycle
        @(negedge clk);
        check(done_o == 1'b0, "R6", 32'(done_o), 0);
        check_regs("R4");

        finished = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", n_checks, n_err);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!finished) begin
            n_checks++;
            n_err++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", n_checks, n_err);
            $finish;
        end
    end

endmodule